// File: doc/BRIEF.md
# Custom Interrupt Instruction Unit

This block carries out the interrupt-management instructions of a small 32-bit RISC-V style core. These instructions sit in the custom-0 major opcode space. The core hands the block a decoded instruction: the opcode and funct7 fields, the low bits of the rs1 and rd specifiers, the value read for rs1 and the instruction's PC. A one-cycle valid pulse marks that instruction. The block then returns a register write, a PC redirect, or a fetch stall. It keeps a small bank of scratch registers for interrupt handlers, an interrupt mask, a pending register and a down-counting timer. It also drives the global interrupt-enable flag and a sticky halt flag.

Interrupt entry itself belongs to the surrounding core. Here it is seen only as a pulse that carries the return PC. That pulse saves the return PC into scratch register 0, turns interrupts off and retires the pending sources it serviced. The return instruction jumps back through scratch register 0 and turns interrupts on again. The wait instruction holds fetch until some unmasked source is pending. It then reports the pending set and resumes at the next instruction.

Top module: `irq_insn_unit`

## Requirements
- R1: An instruction acts only when opcode equals 7'b0001011 and funct7 is one of 7'b0000000 (read scratch), 7'b0000001 (write scratch), 7'b0000010 (return), 7'b0000011 (mask swap), 7'b0000100 (wait), 7'b0000101 (timer). Any other opcode or funct7 produces no write, redirect or stall.
- R2: The read-scratch instruction writes scratch register rs1_field[1:0] to rd. The write-scratch instruction stores rs1_value into scratch register rd_field[1:0]. The upper specifier bits are ignored.
- R3: The return instruction redirects to the value of scratch register 0 and sets irq_en to 1.
- R4: The mask-swap instruction returns the old mask in rd and loads rs1_value as the new mask, in one operation. A 1 in the mask disables that source.
- R5: After reset the mask is all ones and irq_en is 1. halted, stall, rd_we and redirect are all 0.
- R6: A high request line sets its pending bit, and the bit stays set until interrupt entry services it. The value reported to software is the pending bits ANDed with the inverted mask.
- R7: A wait issued while some reported pending bit is set completes one cycle later without stalling. It writes the reported pending set to rd and redirects to instr_pc+4.
- R8: A wait issued with nothing reported pending raises stall and keeps it high. In the cycle after a reported pending bit appears, stall drops and the block writes that set to rd and redirects to instr_pc+4.
- R9: The timer instruction returns the counter's current value in rd and loads rs1_value. A nonzero counter drops by one each cycle. The step from 1 to 0 sets pending bit 0. A zero counter stays at zero.
- R10: An illegal-instruction event uses source bit 1 and a bus-error event uses source bit 2. While its bit is masked, the event sets halted permanently, and a halted block ignores instructions. While its bit is unmasked, the event sets its pending bit instead.
- R11: An interrupt-entry pulse writes entry_pc into scratch register 0, clears irq_en and clears the reported pending bits. It takes precedence over an instruction in the same cycle, and that instruction is dropped.
- R12: A result aimed at rd x0 never asserts rd_we.
- R13: Results appear on the registered outputs one cycle after the instruction is sampled. rd_we and redirect are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Pulse marking a valid instruction this cycle |
| instr_opcode | input | 7 | Opcode field of the instruction |
| instr_funct7 | input | 7 | funct7 field of the instruction |
| instr_rs1_field | input | 5 | rs1 specifier |
| instr_rd_field | input | 5 | rd specifier |
| rs1_value | input | 32 | Value read for rs1 |
| instr_pc | input | 32 | PC of the instruction |
| irq_lines | input | 32 | Interrupt request lines, one per source |
| fault_illegal | input | 1 | Illegal-instruction event |
| fault_bus | input | 1 | Bus-error event |
| irq_entry | input | 1 | Interrupt-entry pulse from the core |
| entry_pc | input | 32 | Return PC captured on interrupt entry |
| rd_we | output | 1 | Register write enable |
| rd_addr | output | 5 | Register write address |
| rd_data | output | 32 | Register write data |
| redirect | output | 1 | PC redirect pulse |
| redirect_pc | output | 32 | Redirect target |
| stall | output | 1 | Fetch stall while waiting |
| irq_en | output | 1 | Global interrupt enable |
| halted | output | 1 | Sticky halt flag |

## Verification
The bench first targets the wait instruction in three situations: when an interrupt is already pending, when one arrives later from a request line, and when one comes from timer expiry. A design that compared raw pending bits instead of the reported set would report masked sources. A design with an off-by-one in the wait exit would show the wrong number of stalled cycles. Next the bench drives an interrupt entry in the same cycle as a write to scratch register 0. Wrong priority would leave the instruction's value in the register instead of the return PC. Faults are raised both masked and unmasked, to catch a halt that fires on the wrong side of the mask. The swap is exercised by random read and write sequences against a model. A broken swap returns the new mask rather than the old one.

// File: rtl/ciu_pkg.sv
package ciu_pkg;

  localparam logic [6:0] OPC_CUSTOM0 = 7'b0001011;

  localparam logic [6:0] F7_QREAD  = 7'b0000000;
  localparam logic [6:0] F7_QWRITE = 7'b0000001;
  localparam logic [6:0] F7_RETURN = 7'b0000010;
  localparam logic [6:0] F7_MSWAP  = 7'b0000011;
  localparam logic [6:0] F7_WAIT   = 7'b0000100;
  localparam logic [6:0] F7_TIMER  = 7'b0000101;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_QREAD,
    OP_QWRITE,
    OP_RETURN,
    OP_MSWAP,
    OP_WAIT,
    OP_TIMER
  } ciu_op_e;

  typedef enum logic {
    ST_RUN,
    ST_WAIT
  } ciu_state_e;

endpackage

// File: rtl/ciu_decode.sv
module ciu_decode
  import ciu_pkg::*;
(
  input  logic       en,
  input  logic [6:0] opcode,
  input  logic [6:0] funct7,
  output ciu_op_e    op
);

  always_comb begin
    op = OP_NONE;
    if (en && opcode == OPC_CUSTOM0) begin
      case (funct7)
        F7_QREAD:  op = OP_QREAD;
        F7_QWRITE: op = OP_QWRITE;
        F7_RETURN: op = OP_RETURN;
        F7_MSWAP:  op = OP_MSWAP;
        F7_WAIT:   op = OP_WAIT;
        F7_TIMER:  op = OP_TIMER;
        default:   op = OP_NONE;
      endcase
    end
  end

endmodule

// File: rtl/ciu_qfile.sv
module ciu_qfile #(
  parameter int XLEN = 32,
  parameter int NQ   = 4,
  localparam int QW  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [QW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [QW-1:0]   raddr,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] q0
);

  logic [XLEN-1:0] bank [NQ];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NQ; i++) bank[i] <= '0;
    end else if (we) begin
      bank[waddr] <= wdata;
    end
  end

  assign rdata = bank[raddr];
  assign q0    = bank[0];

  AST_Q_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    we |=> bank[$past(waddr)] == $past(wdata)); // R2

endmodule

// File: rtl/ciu_irqctl.sv
module ciu_irqctl #(
  parameter int XLEN    = 32,
  parameter int TMR_BIT = 0,
  parameter int ILL_BIT = 1,
  parameter int BUS_BIT = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] lines,
  input  logic            fault_ill,
  input  logic            fault_bus,
  input  logic            mask_we,
  input  logic [XLEN-1:0] mask_wdata,
  input  logic            timer_we,
  input  logic [XLEN-1:0] timer_wdata,
  input  logic            entry,
  input  logic            ret,
  output logic [XLEN-1:0] mask_q,
  output logic [XLEN-1:0] visible,
  output logic [XLEN-1:0] timer_q,
  output logic            en_q,
  output logic            halt_q
);

  logic [XLEN-1:0] pend_q;
  logic [XLEN-1:0] set_vec;
  logic [XLEN-1:0] clr_vec;
  logic            tmr_fire;
  logic            halt_req;

  assign visible  = pend_q & ~mask_q;
  assign tmr_fire = !timer_we && timer_q == XLEN'(1);
  assign clr_vec  = entry ? visible : '0;

  always_comb begin
    set_vec = lines;
    if (tmr_fire) set_vec[TMR_BIT] = 1'b1;
    if (fault_ill && !mask_q[ILL_BIT]) set_vec[ILL_BIT] = 1'b1;
    if (fault_bus && !mask_q[BUS_BIT]) set_vec[BUS_BIT] = 1'b1;
  end

  assign halt_req = (fault_ill && mask_q[ILL_BIT]) || (fault_bus && mask_q[BUS_BIT]);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      pend_q  <= '0;
      timer_q <= '0;
      en_q    <= 1'b1;
      halt_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      if (timer_we) timer_q <= timer_wdata;
      else if (timer_q != '0) timer_q <= timer_q - XLEN'(1);
      if (entry) en_q <= 1'b0;
      else if (ret) en_q <= 1'b1;
      if (halt_req) halt_q <= 1'b1;
    end
  end

  AST_MASK_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mask_q == '1); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> halt_q); // R10
  AST_TIMER_DOWN: assert property (@(posedge clk) disable iff (rst)
    (timer_q != '0 && !timer_we) |=> timer_q == $past(timer_q) - XLEN'(1)); // R9
  AST_ENTRY_DISABLES: assert property (@(posedge clk) disable iff (rst)
    entry |=> !en_q); // R11
  AST_PEND_HELD: assert property (@(posedge clk) disable iff (rst)
    !entry |=> (pend_q & $past(pend_q)) == $past(pend_q)); // R6

endmodule

// File: rtl/irq_insn_unit.sv
module irq_insn_unit
  import ciu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NQ   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            instr_valid,
  input  logic [6:0]      instr_opcode,
  input  logic [6:0]      instr_funct7,
  input  logic [4:0]      instr_rs1_field,
  input  logic [4:0]      instr_rd_field,
  input  logic [XLEN-1:0] rs1_value,
  input  logic [XLEN-1:0] instr_pc,
  input  logic [XLEN-1:0] irq_lines,
  input  logic            fault_illegal,
  input  logic            fault_bus,
  input  logic            irq_entry,
  input  logic [XLEN-1:0] entry_pc,
  output logic            rd_we,
  output logic [4:0]      rd_addr,
  output logic [XLEN-1:0] rd_data,
  output logic            redirect,
  output logic [XLEN-1:0] redirect_pc,
  output logic            stall,
  output logic            irq_en,
  output logic            halted
);

  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1;
  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  ciu_state_e      state_q;
  ciu_op_e         op;
  logic            accept;
  logic [4:0]      wait_rd_q;
  logic [XLEN-1:0] wait_pc_q;

  logic            q_we;
  logic [QW-1:0]   q_waddr;
  logic [XLEN-1:0] q_wdata;
  logic [XLEN-1:0] q_rdata;
  logic [XLEN-1:0] q0_val;

  logic [XLEN-1:0] mask_val;
  logic [XLEN-1:0] vis_pend;
  logic [XLEN-1:0] timer_val;

  assign accept = instr_valid && !halted && !irq_entry && state_q == ST_RUN;

  ciu_decode u_dec (
    .en     (accept),
    .opcode (instr_opcode),
    .funct7 (instr_funct7),
    .op     (op)
  );

  assign q_we    = irq_entry || op == OP_QWRITE;
  assign q_waddr = irq_entry ? '0 : instr_rd_field[QW-1:0];
  assign q_wdata = irq_entry ? entry_pc : rs1_value;

  ciu_qfile #(.XLEN(XLEN), .NQ(NQ)) u_q (
    .clk   (clk),
    .rst   (rst),
    .we    (q_we),
    .waddr (q_waddr),
    .wdata (q_wdata),
    .raddr (instr_rs1_field[QW-1:0]),
    .rdata (q_rdata),
    .q0    (q0_val)
  );

  ciu_irqctl #(.XLEN(XLEN)) u_irq (
    .clk         (clk),
    .rst         (rst),
    .lines       (irq_lines),
    .fault_ill   (fault_illegal),
    .fault_bus   (fault_bus),
    .mask_we     (op == OP_MSWAP),
    .mask_wdata  (rs1_value),
    .timer_we    (op == OP_TIMER),
    .timer_wdata (rs1_value),
    .entry       (irq_entry),
    .ret         (op == OP_RETURN),
    .mask_q      (mask_val),
    .visible     (vis_pend),
    .timer_q     (timer_val),
    .en_q        (irq_en),
    .halt_q      (halted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      rd_we       <= 1'b0;
      rd_addr     <= '0;
      rd_data     <= '0;
      redirect    <= 1'b0;
      redirect_pc <= '0;
      stall       <= 1'b0;
      wait_rd_q   <= '0;
      wait_pc_q   <= '0;
    end else begin
      rd_we    <= 1'b0;
      redirect <= 1'b0;
      case (state_q)
        ST_RUN: begin
          case (op)
            OP_QREAD: begin
              rd_we   <= instr_rd_field != '0;
              rd_addr <= instr_rd_field;
              rd_data <= q_rdata;
            end
            OP_MSWAP: begin
              rd_we   <= instr_rd_field != '0;
              rd_addr <= instr_rd_field;
              rd_data <= mask_val;
            end
            OP_TIMER: begin
              rd_we   <= instr_rd_field != '0;
              rd_addr <= instr_rd_field;
              rd_data <= timer_val;
            end
            OP_RETURN: begin
              redirect    <= 1'b1;
              redirect_pc <= q0_val;
            end
            OP_WAIT: begin
              if (vis_pend != '0) begin
                rd_we       <= instr_rd_field != '0;
                rd_addr     <= instr_rd_field;
                rd_data     <= vis_pend;
                redirect    <= 1'b1;
                redirect_pc <= instr_pc + INSN_BYTES;
              end else begin
                state_q   <= ST_WAIT;
                stall     <= 1'b1;
                wait_rd_q <= instr_rd_field;
                wait_pc_q <= instr_pc + INSN_BYTES;
              end
            end
            default: ;
          endcase
        end
        ST_WAIT: begin
          if (irq_entry) begin
            state_q <= ST_RUN;
            stall   <= 1'b0;
          end else if (vis_pend != '0) begin
            state_q     <= ST_RUN;
            stall       <= 1'b0;
            rd_we       <= wait_rd_q != '0;
            rd_addr     <= wait_rd_q;
            rd_data     <= vis_pend;
            redirect    <= 1'b1;
            redirect_pc <= wait_pc_q;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  AST_STALL_FROM_WAIT: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> $past(op == OP_WAIT)); // R8
  AST_NO_REDIRECT_IN_STALL: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !stall); // R8
  AST_NO_X0_WRITE: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> rd_addr != '0); // R12
  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (rst)
    ($past(op == OP_RETURN) && !$past(rst)) |-> (redirect && redirect_pc == $past(q0_val))); // R3
  AST_HALT_BLOCKS_OPS: assert property (@(posedge clk) disable iff (rst)
    halted |-> op == OP_NONE); // R10

endmodule

// File: tb/tb_irq_insn_unit.sv
`timescale 1ns/1ps
module tb_irq_insn_unit;
  import ciu_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [6:0]  instr_opcode = '0;
  logic [6:0]  instr_funct7 = '0;
  logic [4:0]  instr_rs1_field = '0;
  logic [4:0]  instr_rd_field = '0;
  logic [31:0] rs1_value = '0;
  logic [31:0] instr_pc = '0;
  logic [31:0] irq_lines = '0;
  logic        fault_illegal = 1'b0;
  logic        fault_bus = 1'b0;
  logic        irq_entry = 1'b0;
  logic [31:0] entry_pc = '0;
  logic        rd_we;
  logic [4:0]  rd_addr;
  logic [31:0] rd_data;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic        stall;
  logic        irq_en;
  logic        halted;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  logic [31:0] mq [4];
  logic [31:0] mmask;

  irq_insn_unit dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_opcode(instr_opcode),
    .instr_funct7(instr_funct7), .instr_rs1_field(instr_rs1_field),
    .instr_rd_field(instr_rd_field), .rs1_value(rs1_value), .instr_pc(instr_pc),
    .irq_lines(irq_lines), .fault_illegal(fault_illegal), .fault_bus(fault_bus),
    .irq_entry(irq_entry), .entry_pc(entry_pc), .rd_we(rd_we), .rd_addr(rd_addr),
    .rd_data(rd_data), .redirect(redirect), .redirect_pc(redirect_pc),
    .stall(stall), .irq_en(irq_en), .halted(halted)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] reported(input logic [31:0] pend, input logic [31:0] msk);
    return pend & ~msk;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with results visible.
  task automatic issue_raw(input logic [6:0] opc, input logic [6:0] f7, input logic [4:0] rs1f,
                           input logic [4:0] rdf, input logic [31:0] val, input logic [31:0] pc);
    instr_opcode    = opc;
    instr_funct7    = f7;
    instr_rs1_field = rs1f;
    instr_rd_field  = rdf;
    rs1_value       = val;
    instr_pc        = pc;
    instr_valid     = 1'b1;
    @(negedge clk);
    instr_valid     = 1'b0;
  endtask

  task automatic issue(input logic [6:0] f7, input logic [4:0] rs1f, input logic [4:0] rdf,
                       input logic [31:0] val, input logic [31:0] pc);
    issue_raw(OPC_CUSTOM0, f7, rs1f, rdf, val, pc);
  endtask

  task automatic pulse_line(input int b);
    irq_lines = 32'h1 << b;
    @(negedge clk);
    irq_lines = '0;
  endtask

  task automatic enter_and_return(input logic [31:0] epc);
    irq_entry = 1'b1;
    entry_pc  = epc;
    @(negedge clk);
    irq_entry = 1'b0;
    issue(F7_RETURN, 5'd0, 5'd0, 32'd0, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL R8 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    void'($urandom(32'd20150626));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R5 reset state
    chk("R5 rd_we", 32'(rd_we), 32'd0);
    chk("R5 redirect", 32'(redirect), 32'd0);
    chk("R5 stall", 32'(stall), 32'd0);
    chk("R5 irq_en", 32'(irq_en), 32'd1);
    chk("R5 halted", 32'(halted), 32'd0);
    issue(F7_MSWAP, 5'd1, 5'd5, 32'h0, 32'h0);
    chk("R5 mask all ones", rd_data, 32'hFFFF_FFFF);
    chk("R4 swap rd_we", 32'(rd_we), 32'd1);
    chk("R13 rd_addr", 32'(rd_addr), 32'd5);
    mmask = 32'h0;

    // R1 foreign opcode and unknown funct7
    issue_raw(7'b0110011, F7_QREAD, 5'd0, 5'd3, 32'h0, 32'h0);
    chk("R1 foreign opcode", 32'({rd_we, redirect, stall}), 32'd0);
    issue(7'b0000110, 5'd0, 5'd3, 32'h0, 32'h0);
    chk("R1 unknown funct7", 32'({rd_we, redirect, stall}), 32'd0);
    issue(7'b1000000, 5'd0, 5'd3, 32'h0, 32'h0);
    chk("R1 high funct7 bit", 32'({rd_we, redirect, stall}), 32'd0);

    // R12 x0 destination
    issue(F7_QREAD, 5'd0, 5'd0, 32'h0, 32'h0);
    chk("R12 x0 suppressed", 32'(rd_we), 32'd0);

    // R2 / R4 random scratch and mask traffic
    for (int i = 0; i < 4; i++) mq[i] = '0;
    for (int i = 0; i < 60; i++) begin
      int unsigned k;
      logic [1:0]  qi;
      logic [31:0] v;
      logic [4:0]  rdn;
      k   = $urandom % 3;
      qi  = 2'($urandom);
      v   = $urandom;
      rdn = 5'(1 + ($urandom % 31));
      case (k)
        0: begin
          issue(F7_QWRITE, 5'($urandom), {3'($urandom), qi}, v, 32'h0);
          chk("R2 write gives no rd", 32'(rd_we), 32'd0);
          mq[qi] = v;
        end
        1: begin
          issue(F7_QREAD, {3'($urandom), qi}, rdn, v, 32'h0);
          chk("R2 read value", rd_data, mq[qi]);
          chk("R2 read we/addr", 32'({rd_we, rd_addr}), 32'({1'b1, rdn}));
        end
        default: begin
          issue(F7_MSWAP, 5'd1, rdn, v, 32'h0);
          chk("R4 old mask", rd_data, mmask);
          mmask = v;
        end
      endcase
    end
    issue(F7_MSWAP, 5'd1, 5'd2, 32'hFFFF_0000, 32'h0);
    chk("R4 old mask final", rd_data, mmask);
    mmask = 32'hFFFF_0000;

    // R6 / R7 immediate wait with masked source
    pulse_line(20);
    pulse_line(3);
    issue(F7_WAIT, 5'd0, 5'd7, 32'h0, 32'h100);
    chk("R7 reported set", rd_data, reported(32'h0010_0008, mmask));
    chk("R7 target", redirect_pc, 32'h104);
    chk("R7 we/redirect/stall", 32'({rd_we, redirect, stall}), 32'b110);
    @(negedge clk);
    chk("R13 pulses end", 32'({rd_we, redirect}), 32'd0);
    issue(F7_MSWAP, 5'd1, 5'd2, 32'h0, 32'h0);
    chk("R4 swap back", rd_data, 32'hFFFF_0000);
    issue(F7_WAIT, 5'd0, 5'd7, 32'h0, 32'h100);
    chk("R6 pending held", rd_data, 32'h0010_0008);

    // R11 entry, R3 return
    irq_entry = 1'b1;
    entry_pc  = 32'h2000;
    @(negedge clk);
    irq_entry = 1'b0;
    chk("R11 irq_en off", 32'(irq_en), 32'd0);
    issue(F7_QREAD, 5'd0, 5'd1, 32'h0, 32'h0);
    chk("R11 q0 saved", rd_data, 32'h2000);
    issue(F7_RETURN, 5'd0, 5'd0, 32'h0, 32'h0);
    chk("R3 redirect", 32'(redirect), 32'd1);
    chk("R3 target", redirect_pc, 32'h2000);
    chk("R3 irq_en on", 32'(irq_en), 32'd1);

    // R11 entry wins over same-cycle write of q0
    irq_entry = 1'b1;
    entry_pc  = 32'h3000;
    issue(F7_QWRITE, 5'd1, 5'd0, 32'h5555, 32'h0);
    irq_entry = 1'b0;
    issue(F7_QREAD, 5'd0, 5'd1, 32'h0, 32'h0);
    chk("R11 entry priority", rd_data, 32'h3000);
    issue(F7_RETURN, 5'd0, 5'd0, 32'h0, 32'h0);

    // R9 timer readback and countdown
    issue(F7_TIMER, 5'd1, 5'd4, 32'd5, 32'h0);
    chk("R9 old value zero", rd_data, 32'd0);
    @(negedge clk);
    @(negedge clk);
    issue(F7_TIMER, 5'd0, 5'd4, 32'd0, 32'h0);
    chk("R9 counted down", rd_data, 32'd3);
    issue(F7_TIMER, 5'd1, 5'd4, 32'd3, 32'h0);
    issue(F7_WAIT, 5'd0, 5'd6, 32'h0, 32'h200);
    cnt = 0;
    for (int t = 0; t < 20 && !rd_we; t++) begin
      if (stall) cnt++;
      @(negedge clk);
    end
    chk("R9 stall cycles to expiry", 32'(cnt), 32'd3);
    chk("R9 timer pending bit", rd_data, 32'h1);
    chk("R8 wait target", redirect_pc, 32'h204);
    enter_and_return(32'h0);

    // R8 wait released by a later request line
    issue(F7_WAIT, 5'd0, 5'd9, 32'h0, 32'h400);
    for (int t = 0; t < 4; t++) begin
      chk("R8 still stalled", 32'({stall, rd_we}), 32'b10);
      @(negedge clk);
    end
    pulse_line(7);
    chk("R8 no result yet", 32'({stall, rd_we}), 32'b10);
    @(negedge clk);
    chk("R8 released", 32'({stall, rd_we, redirect}), 32'b011);
    chk("R8 reported set", rd_data, 32'h80);
    chk("R8 target", redirect_pc, 32'h404);
    enter_and_return(32'h0);

    // R10 faults
    fault_illegal = 1'b1;
    @(negedge clk);
    fault_illegal = 1'b0;
    chk("R10 unmasked no halt", 32'(halted), 32'd0);
    issue(F7_WAIT, 5'd0, 5'd3, 32'h0, 32'h0);
    chk("R10 illegal pending", rd_data, 32'h2);
    enter_and_return(32'h0);
    issue(F7_MSWAP, 5'd1, 5'd2, 32'h4, 32'h0);
    chk("R4 mask before fault", rd_data, 32'h0);
    fault_bus = 1'b1;
    @(negedge clk);
    fault_bus = 1'b0;
    chk("R10 masked halts", 32'(halted), 32'd1);
    issue(F7_QREAD, 5'd0, 5'd5, 32'h0, 32'h0);
    chk("R10 halted ignores", 32'(rd_we), 32'd0);
    @(negedge clk);
    chk("R10 halt sticky", 32'(halted), 32'd1);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule